// File: doc/BRIEF.md
# E1 Timeslot-16 Signalling Multiframe Inserter

This block produces the timeslot 16 octet for every frame of a 16-frame channel-associated signalling multiframe on a 2048 kbit/s line. The framer supplies a one-cycle frame-start strobe and the index of the frame, 0 to 15, within the signalling multiframe. At each strobe the block registers the octet for that frame. Frame 0 carries a four-zero multiframe alignment word, the outgoing alarm bit and three spare bits. Frames 1 to 15 each carry the four signalling bits (a, b, c, d) of two of the thirty voice channels. Each channel therefore receives 2 kbit/s of signalling.

Signalling values come in through a register write port and land in a staging table. They are copied into the table that is in use only at a multiframe boundary, so that a channel's four bits stay the same for a whole multiframe. Two rules protect the line. A channel code of all zeros would imitate the alignment word, so 0001 is sent in its place. While the far end reports a remote alarm, every signalling bit in frames 1 to 15 is sent as one.

Top module: `cas_mf_inserter`

## Requirements
- R1: The octet for frame index 0 is, from bit 7 down to bit 0: 0, 0, 0, 0, spare_bits[2], alarm_req, spare_bits[1], spare_bits[0].
- R2: The octet for frame index n (1 to 15) holds channel n's a,b,c,d in bits 7..4 and channel n+15's a,b,c,d in bits 3..0, with a in the most significant position of each nibble.
- R3: While far_alarm is high at a frame start with index 1 to 15, the octet is 8'hFF. The frame-0 octet is not affected by far_alarm.
- R4: A channel whose stored code is 4'b0000 is sent as 4'b0001.
- R5: A write (wr_en high, wr_chan = channel number, wr_abcd = code) reaches the line only from the next frame start with index 0. A write made in the same cycle as that boundary strobe is included at that boundary.
- R6: A write with wr_chan of 0 or 31 changes no channel.
- R7: ts16_byte changes only on the clock edge that follows a frame_start pulse. In all other cycles it holds, whatever alarm_req, spare_bits or far_alarm do.
- R8: After synchronous reset, ts16_byte is 8'h0B, and every channel, in both the staging table and the table in use, holds 4'b1101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| frame_idx | input | 4 | Frame number within the signalling multiframe, 0 to 15 |
| wr_en | input | 1 | Signalling table write enable |
| wr_chan | input | 5 | Channel number to write, 1 to 30 |
| wr_abcd | input | 4 | a,b,c,d code to write, a in bit 3 |
| alarm_req | input | 1 | Outgoing alarm bit for the frame-0 octet |
| spare_bits | input | 3 | Spare bit values for the frame-0 octet |
| far_alarm | input | 1 | Remote alarm received: force all signalling bits to one |
| ts16_byte | output | 8 | Timeslot 16 octet for the current frame, bit 7 sent first |

## Verification
A table write and the multiframe boundary strobe can occur in the same clock cycle. The bench drives wr_en together with frame_start at index 0. It then reads the rewritten channel's frame in the multiframe that follows, and expects the new code there rather than the old one. The bench also writes a channel in the middle of a multiframe and reads that channel's frame before and after the next boundary. This separates a write that is held for the boundary from one that reaches the line early.

// File: rtl/e1cas_pkg.sv
package e1cas_pkg;

    localparam int ABCD_W    = 4;
    localparam int OCTET_W   = 8;

    typedef logic [ABCD_W-1:0]  abcd_t;
    typedef logic [OCTET_W-1:0] octet_t;

    // Layout of the frame-0 octet, bit 7 first on the line
    typedef struct packed {
        logic [3:0] align;
        logic       spare_hi;
        logic       alarm;
        logic [1:0] spare_lo;
    } f0_octet_t;

    localparam abcd_t  ABCD_AFTER_RESET = 4'b1101;
    localparam abcd_t  ABCD_ZERO_SUB    = 4'b0001;
    localparam octet_t OCTET_ALL_ONES   = 8'hFF;

    function automatic abcd_t zero_guard(abcd_t v);
        return (v == '0) ? ABCD_ZERO_SUB : v;
    endfunction

    function automatic octet_t build_f0(logic [2:0] spare, logic alarm);
        f0_octet_t o;
        o.align    = 4'b0000;
        o.spare_hi = spare[2];
        o.alarm    = alarm;
        o.spare_lo = spare[1:0];
        return octet_t'(o);
    endfunction

    localparam octet_t OCTET_AFTER_RESET = 8'h0B;

endpackage

// File: rtl/cas_sig_table.sv
module cas_sig_table
    import e1cas_pkg::*;
#(
    parameter int NUM_CH = 30,
    parameter int CHN_W  = $clog2(NUM_CH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CHN_W-1:0] wr_chan,
    input  abcd_t            wr_abcd,
    input  logic             mf_load,
    output abcd_t            live [NUM_CH]
);

    abcd_t staged [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic  hit;
        abcd_t staged_next;

        always_comb begin
            hit         = wr_en && (wr_chan == CHN_W'(i + 1));
            staged_next = hit ? wr_abcd : staged[i];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                staged[i] <= ABCD_AFTER_RESET;
                live[i]   <= ABCD_AFTER_RESET;
            end else begin
                staged[i] <= staged_next;
                if (mf_load) begin
                    live[i] <= staged_next;
                end
            end
        end

        // R5: the table in use moves only at a multiframe boundary
        a_r5_live_hold: assert property (@(posedge clk) disable iff (rst)
            !mf_load |=> $stable(live[i]));
    end

endmodule

// File: rtl/cas_ts16_builder.sv
module cas_ts16_builder
    import e1cas_pkg::*;
#(
    parameter int NUM_CH = 30,
    parameter int FIDX_W = $clog2(NUM_CH / 2 + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic [FIDX_W-1:0] frame_idx,
    input  abcd_t             live [NUM_CH],
    input  logic              alarm_req,
    input  logic [2:0]        spare_bits,
    input  logic              far_alarm,
    output octet_t            ts16_byte
);

    localparam int HALF  = NUM_CH / 2;
    localparam int SEL_W = $clog2(NUM_CH);

    logic [SEL_W-1:0] hi_sel, lo_sel;
    logic             is_f0;
    octet_t           next_octet;

    always_comb begin
        is_f0  = (frame_idx == '0);
        hi_sel = is_f0 ? '0 : SEL_W'(frame_idx) - SEL_W'(1);
        lo_sel = hi_sel + SEL_W'(HALF);
        if (is_f0) begin
            next_octet = build_f0(spare_bits, alarm_req);
        end else if (far_alarm) begin
            next_octet = OCTET_ALL_ONES;
        end else begin
            next_octet = {zero_guard(live[hi_sel]), zero_guard(live[lo_sel])};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ts16_byte <= OCTET_AFTER_RESET;
        end else if (frame_start) begin
            ts16_byte <= next_octet;
        end
    end

    // R1: the frame-0 octet starts with the four-zero alignment word
    a_r1_align_word: assert property (@(posedge clk) disable iff (rst)
        (frame_start && frame_idx == '0) |=> (ts16_byte[7:4] == 4'b0000));

    // R3: the remote alarm forces the signalling octets to all ones
    a_r3_forced_ones: assert property (@(posedge clk) disable iff (rst)
        (frame_start && frame_idx != '0 && far_alarm) |=> (ts16_byte == 8'hFF));

    // R4: no signalling nibble is ever all zeros
    a_r4_no_zero_nibble: assert property (@(posedge clk) disable iff (rst)
        (frame_start && frame_idx != '0) |=>
            (ts16_byte[7:4] != 4'b0000 && ts16_byte[3:0] != 4'b0000));

    // R7: the octet holds between frame starts
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(ts16_byte));

endmodule

// File: rtl/cas_mf_inserter.sv
module cas_mf_inserter
    import e1cas_pkg::*;
#(
    parameter int NUM_CH = 30,
    parameter int FIDX_W = $clog2(NUM_CH / 2 + 1),
    parameter int CHN_W  = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic [FIDX_W-1:0] frame_idx,
    input  logic              wr_en,
    input  logic [CHN_W-1:0]  wr_chan,
    input  logic [3:0]        wr_abcd,
    input  logic              alarm_req,
    input  logic [2:0]        spare_bits,
    input  logic              far_alarm,
    output logic [7:0]        ts16_byte
);

    abcd_t live [NUM_CH];
    logic  mf_load;

    assign mf_load = frame_start && (frame_idx == '0);

    cas_sig_table #(
        .NUM_CH (NUM_CH),
        .CHN_W  (CHN_W)
    ) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_chan (wr_chan),
        .wr_abcd (wr_abcd),
        .mf_load (mf_load),
        .live    (live)
    );

    cas_ts16_builder #(
        .NUM_CH (NUM_CH),
        .FIDX_W (FIDX_W)
    ) u_build (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .frame_idx   (frame_idx),
        .live        (live),
        .alarm_req   (alarm_req),
        .spare_bits  (spare_bits),
        .far_alarm   (far_alarm),
        .ts16_byte   (ts16_byte)
    );

endmodule

// File: tb/cas_mf_inserter_test.sv
module cas_mf_inserter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_start = 1'b0;
    logic [3:0] frame_idx = '0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_chan = '0;
    logic [3:0] wr_abcd = '0;
    logic       alarm_req = 1'b0;
    logic [2:0] spare_bits = 3'b111;
    logic       far_alarm = 1'b0;
    logic [7:0] ts16_byte;

    int n_run = 0;
    int n_fail = 0;
    logic [3:0] stage_m [1:30];
    logic [3:0] live_m  [1:30];

    always #2 clk = ~clk;

    cas_mf_inserter uut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .frame_idx(frame_idx),
        .wr_en(wr_en), .wr_chan(wr_chan), .wr_abcd(wr_abcd),
        .alarm_req(alarm_req), .spare_bits(spare_bits), .far_alarm(far_alarm),
        .ts16_byte(ts16_byte)
    );

    function automatic logic [3:0] g(logic [3:0] v);
        return (v == 4'b0000) ? 4'b0001 : v;
    endfunction

    function automatic logic [7:0] expect_octet(int idx);
        if (idx == 0) return {4'b0000, spare_bits[2], alarm_req, spare_bits[1:0]};
        if (far_alarm) return 8'hFF;
        return {g(live_m[idx]), g(live_m[idx + 15])};
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic send_frame(int idx, string req);
        logic [7:0] e;
        @(negedge clk);
        frame_start = 1'b1;
        frame_idx   = 4'(idx);
        e = expect_octet(idx);
        @(negedge clk);
        frame_start = 1'b0;
        if (idx == 0) for (int c = 1; c <= 30; c++) live_m[c] = stage_m[c];
        check(req, ts16_byte, e);
    endtask

    task automatic write_ch(int ch, logic [3:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_chan = 5'(ch); wr_abcd = v;
        @(negedge clk);
        wr_en = 1'b0;
        if (ch >= 1 && ch <= 30) stage_m[ch] = v;
    endtask

    task automatic t_reset;
        for (int c = 1; c <= 30; c++) begin stage_m[c] = 4'b1101; live_m[c] = 4'b1101; end
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 reset octet", ts16_byte, 8'h0B);
        send_frame(1, "R8 reset table frame 1");
        send_frame(15, "R8 reset table frame 15");
    endtask

    task automatic t_frame0;
        alarm_req = 1'b1; spare_bits = 3'b010;
        send_frame(0, "R1 frame0 alarm set");
        alarm_req = 1'b0; spare_bits = 3'b101;
        send_frame(0, "R1 frame0 alarm clear");
        spare_bits = 3'b111;
    endtask

    task automatic t_full_mf;
        for (int c = 1; c <= 30; c++) write_ch(c, 4'((c * 7 + 3) % 16));
        for (int f = 0; f < 16; f++) send_frame(f, "R2 channel packing");
    endtask

    task automatic t_mid_write;
        send_frame(0, "R5 boundary");
        write_ch(3, 4'hA);
        write_ch(18, 4'h6);
        send_frame(3, "R5 write held until boundary");
        send_frame(0, "R5 boundary load");
        send_frame(3, "R5 write visible after boundary");
    endtask

    task automatic t_zero;
        write_ch(20, 4'h0);
        write_ch(5, 4'h0);
        send_frame(0, "R4 boundary");
        send_frame(5, "R4 zero code substituted");
    endtask

    task automatic t_far;
        far_alarm = 1'b1;
        send_frame(0, "R3 frame0 unaffected");
        send_frame(7, "R3 forced ones");
        send_frame(15, "R3 forced ones last frame");
        far_alarm = 1'b0;
        send_frame(7, "R3 released");
    endtask

    task automatic t_bad_chan;
        write_ch(0, 4'h7);
        write_ch(31, 4'h7);
        send_frame(0, "R6 boundary");
        for (int f = 1; f < 16; f++) send_frame(f, "R6 invalid channel ignored");
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        frame_start = 1'b1; frame_idx = 4'd0;
        wr_en = 1'b1; wr_chan = 5'd9; wr_abcd = 4'h3;
        @(negedge clk);
        frame_start = 1'b0; wr_en = 1'b0;
        check("R1 frame0 during write", ts16_byte, {4'b0000, spare_bits[2], alarm_req, spare_bits[1:0]});
        stage_m[9] = 4'h3;
        for (int c = 1; c <= 30; c++) live_m[c] = stage_m[c];
        send_frame(9, "R5 write on boundary cycle");
    endtask

    task automatic t_hold;
        logic [7:0] held;
        send_frame(4, "R7 reference");
        held = ts16_byte;
        far_alarm = 1'b1; alarm_req = 1'b1; spare_bits = 3'b000;
        repeat (5) @(negedge clk);
        check("R7 hold between frames", ts16_byte, held);
        far_alarm = 1'b0; alarm_req = 1'b0; spare_bits = 3'b111;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_frame0();
        t_full_mf();
        t_mid_write();
        t_zero();
        t_far();
        t_bad_chan();
        t_same_cycle();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule